// File: doc/BRIEF.md
# Dual-Line Secondary Interrupt Controller

This block gathers up to sixteen interrupt sources inside a peripheral chip and reports them to two bus masters that work on their own. Each source passes through a synchronizer and an edge detector. A per-source select field, shared by both masters, chooses rising edges, falling edges, both or neither. Each master has its own status and mask registers, so it sees and acknowledges only the events it has enabled. A control register picks the acknowledge style. In one style a status read clears the bits it returns. In the other, writing ones clears them. An optional pending mode holds one extra event for a bit that is already set, so the bit comes back one cycle after it is cleared.

A small primary stage builds one summary byte per master. One slot of that byte carries this bank's request and the other slots come from sibling banks. Each master has an active-low interrupt output that is driven low whenever its summary byte is non-zero. All registers are one byte wide and sit behind a synchronous port with address, write enable, write data, read enable and registered read data.

Register map (4-bit byte addresses): 0x0 control (bit 0 = clear-on-read, bit 1 = pending mode), 0x1 summary A, 0x2 summary B, 0x4–0x5 status A, 0x6–0x7 mask A, 0x8–0x9 status B, 0xA–0xB mask B, 0xC–0xF edge select. Unused addresses read zero.

Top module: `dual_line_sirq`

## Requirements
- R1: Source i has a 2-bit edge-select field in byte 0xC + i/4 at bits [2(i mod 4)+1 : 2(i mod 4)]. The upper bit enables rising-edge detection and the lower bit enables falling-edge detection. With both bits set, either edge sets status.
- R2: Every edge-select field resets to 00. A source whose field is 00 never sets status on either line.
- R3: A mask bit of 1 stops its source from setting that line's status bit and removes an already-set bit from that line's request. Mask registers reset to all ones.
- R4: While control bit 0 is 0, writing 1 to a status bit clears it and writing 0 leaves it alone. Reads do not change status.
- R5: While control bit 0 is 1, a status read clears the bits it returns, and writes to status registers have no effect.
- R6: Line A and line B each have their own status and mask registers (A at 0x4/0x6, B at 0x8/0xA). One edge event sets status only on the lines where the source is unmasked.
- R7: While control bit 1 is 1, an edge that arrives on a status bit that is already set is held. The bit sets again on the cycle after a clear. While control bit 1 is 0, such an edge is lost.
- R8: An edge that sets a status bit in the same cycle as a clear of that bit wins, and the bit stays set.
- R9: Summary byte A (0x1) and summary byte B (0x2) carry this bank's unmasked pending request at slot OWN_SLOT. Every other slot copies the matching bit of other_req_a or other_req_b. The input bit at OWN_SLOT is ignored.
- R10: irq_a_n and irq_b_n are low exactly while their summary byte is non-zero.
- R11: A source change driven before clock edge k sets status, and the interrupt output responds, after edge k+2 and not earlier.
- R12: Reading status byte 0 of a line latches a copy of the whole status word. Reads of higher status bytes return that copy, and in clear-on-read mode they clear only the bits that were returned.
- R13: Status and mask bits at positions N_SRC and above read as zero, and writes cannot set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_SRC | Raw interrupt sources, asynchronous |
| other_req_a | input | 8 | Line A requests from sibling banks |
| other_req_b | input | 8 | Line B requests from sibling banks |
| addr | input | 4 | Register byte address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |
| irq_a_n | output | 1 | Active-low interrupt to master A |
| irq_b_n | output | 1 | Active-low interrupt to master B |

## Verification
The bench drives single rising edges, single falling edges and rise-then-fall pairs against each edge-select setting. This separates sources that must fire from sources that must stay quiet, including the 00 "off" setting. Pairs of edges close together are timed so that the second edge lands on a bit that is already set, once with pending mode on and once with it off, and once in exactly the cycle of a clear. This shows buffering apart from loss and shows the set-wins rule. The same edge is seen under different masks on the two lines, and under both acknowledge styles, to show that the lines are independent and that reads only clear in the right mode. Multi-byte reads with an event arriving between the byte accesses show that the latched copy, not the live status, decides what is returned and cleared.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   localparam int REG_AW = 4;

   localparam logic [REG_AW-1:0] RA_CTRL   = 4'h0;
   localparam logic [REG_AW-1:0] RA_PRIM_A = 4'h1;
   localparam logic [REG_AW-1:0] RA_PRIM_B = 4'h2;
   localparam logic [REG_AW-1:0] RA_EDGE   = 4'hC;

   typedef struct packed {
      logic pend_en;
      logic clr_on_rd;
   } ctrl_t;

   function automatic logic [REG_AW-1:0] stat_addr(input int line, input int b);
      return REG_AW'(4 + 4*line + b);
   endfunction

   function automatic logic [REG_AW-1:0] mask_addr(input int line, input int b);
      return REG_AW'(6 + 4*line + b);
   endfunction
endpackage

// File: rtl/sirq_edge.sv
module sirq_edge #(
   parameter int N = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   src,
   input  logic [2*N-1:0] esel,
   output logic [N-1:0]   evt
);
   logic [N-1:0] sync1_q, sync2_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1_q <= '0;
         sync2_q <= '0;
         prev_q  <= '0;
      end else begin
         sync1_q <= src;
         sync2_q <= sync1_q;
         prev_q  <= sync2_q;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      assign evt[i] = (sync2_q[i] & ~prev_q[i] & esel[2*i+1])
                    | (~sync2_q[i] & prev_q[i] & esel[2*i]);
   end
endmodule

// File: rtl/sirq_line.sv
module sirq_line #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         pend_en,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] mwe,
   input  logic [N-1:0] mwd,
   output logic [N-1:0] stat,
   output logic [N-1:0] mask,
   output logic         req
);
   logic [N-1:0] stat_q, pend_q, mask_q;
   logic [N-1:0] set_v, reissue, stat_d, pend_d;

   always_comb begin
      set_v   = evt & ~mask_q;
      reissue = pend_q & ~stat_q;
      stat_d  = set_v | (stat_q & ~clr) | reissue;
      pend_d  = pend_en ? ((pend_q & ~reissue) | (set_v & stat_q & ~clr)) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         pend_q <= '0;
         mask_q <= '1;
      end else begin
         stat_q <= stat_d;
         pend_q <= pend_d;
         mask_q <= (mask_q & ~mwe) | (mwd & mwe);
      end
   end

   assign stat = stat_q;
   assign mask = mask_q;
   assign req  = |(stat_q & ~mask_q);

   // R7: a held event comes back on the cycle after its bit was cleared
   a_r7_reissue: assert property (@(posedge clk) disable iff (!rst_n)
      (reissue != '0) |=> ((stat_q & $past(reissue)) == $past(reissue)));

   // R4: a clear with no competing event leaves the bit at zero
   a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~set_v & stat_q) != '0) |=> ((stat_q & $past(clr & ~set_v & stat_q)) == '0));

   // R8: an event in the clear cycle keeps the bit set
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_v & clr) != '0) |=> ((stat_q & $past(set_v & clr)) == $past(set_v & clr)));

   // R3: a masked, idle, non-pending bit stays clear
   a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      ((~stat_q & mask_q & ~pend_q) != '0) |=> ((stat_q & $past(~stat_q & mask_q & ~pend_q)) == '0));
endmodule

// File: rtl/sirq_primary.sv
module sirq_primary #(
   parameter int OWN_SLOT = 0
) (
   input  logic [1:0] own_req,
   input  logic [7:0] other_a,
   input  logic [7:0] other_b,
   output logic [7:0] prim_a,
   output logic [7:0] prim_b,
   output logic [1:0] irq_n
);
   always_comb begin
      prim_a = other_a;
      prim_b = other_b;
      prim_a[OWN_SLOT] = own_req[0];
      prim_b[OWN_SLOT] = own_req[1];
      irq_n = {~|prim_b, ~|prim_a};
   end
endmodule

// File: rtl/dual_line_sirq.sv
module dual_line_sirq
   import sirq_pkg::*;
#(
   parameter int N_SRC    = 8,
   parameter int OWN_SLOT = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_SRC-1:0]    src_in,
   input  logic [7:0]          other_req_a,
   input  logic [7:0]          other_req_b,
   input  logic [REG_AW-1:0]   addr,
   input  logic                wr_en,
   input  logic [7:0]          wr_data,
   input  logic                rd_en,
   output logic [7:0]          rd_data,
   output logic                irq_a_n,
   output logic                irq_b_n
);
   localparam int SB  = (N_SRC + 7) / 8;
   localparam int EB  = (2*N_SRC + 7) / 8;
   localparam int SBW = 8 * SB;
   localparam int EBW = 8 * EB;
   localparam logic [EBW-1:0] ESEL_OK = (EBW'(1) << (2*N_SRC)) - EBW'(1);

   initial begin
      if (N_SRC < 1 || N_SRC > 16) $fatal(1, "N_SRC must be 1..16");
      if (OWN_SLOT < 0 || OWN_SLOT > 7) $fatal(1, "OWN_SLOT must be 0..7");
   end

   ctrl_t                     ctrl_q;
   logic [EBW-1:0]            esel_q;
   logic [N_SRC-1:0]          evt;
   logic [1:0][N_SRC-1:0]     stat, mask;
   logic [1:0][SBW-1:0]       stat_pad, mask_pad, snap_q, clr_pad, mwe_pad;
   logic [SBW-1:0]            wd_rep;
   logic [1:0]                own_req, irq_n;
   logic [7:0]                prim_a, prim_b, rd_mux;

   assign wd_rep = {SB{wr_data}};

   sirq_edge #(.N(N_SRC)) u_edge (
      .clk(clk), .rst_n(rst_n), .src(src_in),
      .esel(esel_q[2*N_SRC-1:0]), .evt(evt));

   for (genvar l = 0; l < 2; l++) begin : g_line
      sirq_line #(.N(N_SRC)) u_line (
         .clk(clk), .rst_n(rst_n), .evt(evt), .pend_en(ctrl_q.pend_en),
         .clr(clr_pad[l][N_SRC-1:0]), .mwe(mwe_pad[l][N_SRC-1:0]),
         .mwd(wd_rep[N_SRC-1:0]), .stat(stat[l]), .mask(mask[l]),
         .req(own_req[l]));
   end

   sirq_primary #(.OWN_SLOT(OWN_SLOT)) u_prim (
      .own_req(own_req), .other_a(other_req_a), .other_b(other_req_b),
      .prim_a(prim_a), .prim_b(prim_b), .irq_n(irq_n));

   assign irq_a_n = irq_n[0];
   assign irq_b_n = irq_n[1];

   always_comb begin
      for (int l = 0; l < 2; l++) begin
         stat_pad[l] = '0;
         mask_pad[l] = '0;
         stat_pad[l][N_SRC-1:0] = stat[l];
         mask_pad[l][N_SRC-1:0] = mask[l];
      end
   end

   // clear and mask-write vectors, per line and byte
   always_comb begin
      clr_pad = '0;
      mwe_pad = '0;
      for (int l = 0; l < 2; l++) begin
         for (int b = 0; b < SB; b++) begin
            if (wr_en && !ctrl_q.clr_on_rd && addr == stat_addr(l, b))
               clr_pad[l][8*b +: 8] = wr_data;
            if (rd_en && ctrl_q.clr_on_rd && addr == stat_addr(l, b))
               clr_pad[l][8*b +: 8] = (b == 0) ? stat_pad[l][7:0] : snap_q[l][8*b +: 8];
            if (wr_en && addr == mask_addr(l, b))
               mwe_pad[l][8*b +: 8] = 8'hFF;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         esel_q <= '0;
         snap_q <= '0;
      end else begin
         if (wr_en && addr == RA_CTRL) ctrl_q <= ctrl_t'(wr_data[1:0]);
         for (int b = 0; b < EB; b++)
            if (wr_en && addr == REG_AW'(int'(RA_EDGE) + b))
               esel_q[8*b +: 8] <= wr_data & ESEL_OK[8*b +: 8];
         for (int l = 0; l < 2; l++)
            if (rd_en && addr == stat_addr(l, 0)) snap_q[l] <= stat_pad[l];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (addr == RA_CTRL)   rd_mux = {6'd0, ctrl_q};
      if (addr == RA_PRIM_A) rd_mux = prim_a;
      if (addr == RA_PRIM_B) rd_mux = prim_b;
      for (int l = 0; l < 2; l++) begin
         for (int b = 0; b < SB; b++) begin
            if (addr == stat_addr(l, b))
               rd_mux = (b == 0) ? stat_pad[l][7:0] : snap_q[l][8*b +: 8];
            if (addr == mask_addr(l, b))
               rd_mux = mask_pad[l][8*b +: 8];
         end
      end
      for (int b = 0; b < EB; b++)
         if (addr == REG_AW'(int'(RA_EDGE) + b)) rd_mux = esel_q[8*b +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
   end

   // R10: unmasked pending status on line A drives its output low
   a_r10_own_to_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat[0] & ~mask[0]) != '0) |-> !irq_a_n);
endmodule

// File: tb/tb_dual_line_sirq.sv
module tb_dual_line_sirq;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NS-1:0] src_in;
   logic [7:0]    other_req_a, other_req_b;
   logic [3:0]    addr;
   logic          wr_en, rd_en;
   logic [7:0]    wr_data;
   logic [7:0]    rd_data;
   logic          irq_a_n, irq_b_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_line_sirq #(.N_SRC(NS), .OWN_SLOT(0)) dut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in),
      .other_req_a(other_req_a), .other_req_b(other_req_b),
      .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      addr = a; rd_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic wait3();
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(4'h0, v); chk("R4 ctrl reset", v, 8'h00);
      rd(4'h6, v); chk("R3 mask A reset", v, 8'hFF);
      rd(4'h7, v); chk("R13 mask A hi byte", v, 8'h0F);
      rd(4'hA, v); chk("R3 mask B reset", v, 8'hFF);
      rd(4'hC, v); chk("R2 edge select reset", v, 8'h00);
      chk("R10 irq_a idle", {7'd0, irq_a_n}, 8'h01);
      chk("R10 irq_b idle", {7'd0, irq_b_n}, 8'h01);
   endtask

   task automatic t_unselected();
      logic [7:0] v;
      wr(4'h6, 8'h00); wr(4'h7, 8'h00);
      src_in[3] = 1'b1; wait3();
      src_in[3] = 1'b0; wait3();
      rd(4'h4, v); chk("R2 unselected source", v, 8'h00);
      chk("R2 irq_a quiet", {7'd0, irq_a_n}, 8'h01);
   endtask

   task automatic t_rise();
      logic [7:0] v;
      wr(4'hC, 8'h02);
      src_in[0] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R11 not yet asserted", {7'd0, irq_a_n}, 8'h01);
      @(negedge clk);
      chk("R11 asserted after 3 edges", {7'd0, irq_a_n}, 8'h00);
      rd(4'h4, v); chk("R1 rising sets", v, 8'h01);
      wr(4'h4, 8'h01);
      chk("R4 w1c releases irq", {7'd0, irq_a_n}, 8'h01);
      rd(4'h4, v); chk("R4 w1c clears", v, 8'h00);
      src_in[0] = 1'b0; wait3();
      rd(4'h4, v); chk("R1 falling ignored by rise select", v, 8'h00);
   endtask

   task automatic t_fall();
      logic [7:0] v;
      wr(4'hD, 8'h04);
      src_in[5] = 1'b1; wait3();
      rd(4'h4, v); chk("R1 rise ignored by fall select", v, 8'h00);
      src_in[5] = 1'b0; wait3();
      rd(4'h4, v); chk("R1 falling sets", v, 8'h20);
      wr(4'h4, 8'h20);
   endtask

   task automatic t_both();
      logic [7:0] v;
      wr(4'hE, 8'h0C);
      src_in[9] = 1'b1; wait3();
      rd(4'h4, v);
      rd(4'h5, v); chk("R1 both select rise", v, 8'h02);
      wr(4'h5, 8'h02);
      src_in[9] = 1'b0; wait3();
      rd(4'h4, v);
      rd(4'h5, v); chk("R1 both select fall", v, 8'h02);
      wr(4'h5, 8'h02);
   endtask

   task automatic t_mask();
      logic [7:0] v;
      wr(4'h6, 8'h01);
      src_in[0] = 1'b1; wait3();
      rd(4'h4, v); chk("R3 masked no set", v, 8'h00);
      chk("R3 masked irq quiet", {7'd0, irq_a_n}, 8'h01);
      src_in[0] = 1'b0; wait3();
      wr(4'h6, 8'h00);
      src_in[0] = 1'b1; wait3();
      chk("R3 unmasked asserts", {7'd0, irq_a_n}, 8'h00);
      wr(4'h6, 8'h01);
      chk("R3 late mask hides", {7'd0, irq_a_n}, 8'h01);
      rd(4'h4, v); chk("R3 status kept under mask", v, 8'h01);
      wr(4'h4, 8'h01); wr(4'h6, 8'h00);
      src_in[0] = 1'b0; wait3();
   endtask

   task automatic t_w1c_keeps();
      logic [7:0] v;
      src_in[0] = 1'b1; wait3();
      rd(4'h4, v); chk("R4 first read", v, 8'h01);
      rd(4'h4, v); chk("R4 read does not clear", v, 8'h01);
      wr(4'h4, 8'h00);
      rd(4'h4, v); chk("R4 write zero keeps", v, 8'h01);
      wr(4'h4, 8'h01);
      src_in[0] = 1'b0; wait3();
   endtask

   task automatic t_lines();
      logic [7:0] v;
      wr(4'h6, 8'hFF); wr(4'hA, 8'hFE);
      src_in[0] = 1'b1; wait3();
      rd(4'h4, v); chk("R6 line A masked", v, 8'h00);
      rd(4'h8, v); chk("R6 line B set", v, 8'h01);
      chk("R6 irq_a high", {7'd0, irq_a_n}, 8'h01);
      chk("R6 irq_b low", {7'd0, irq_b_n}, 8'h00);
      wr(4'h8, 8'h01);
      chk("R6 irq_b released", {7'd0, irq_b_n}, 8'h01);
      src_in[0] = 1'b0; wait3();
      wr(4'hA, 8'hFF); wr(4'h6, 8'h00);
   endtask

   task automatic t_cor();
      logic [7:0] v;
      wr(4'h0, 8'h01);
      src_in[0] = 1'b1; wait3();
      wr(4'h4, 8'h01);
      rd(4'h4, v); chk("R5 write ignored, read returns", v, 8'h01);
      rd(4'h4, v); chk("R5 read cleared", v, 8'h00);
      chk("R5 irq released", {7'd0, irq_a_n}, 8'h01);
      wr(4'h0, 8'h00);
      src_in[0] = 1'b0; wait3();
   endtask

   task automatic t_pend();
      wr(4'hC, 8'h03);
      wr(4'h0, 8'h02);
      src_in[0] = 1'b1; wait3();
      src_in[0] = 1'b0; wait3();
      wr(4'h4, 8'h01);
      chk("R7 cleared cycle", {7'd0, irq_a_n}, 8'h01);
      @(negedge clk);
      chk("R7 held event reasserts", {7'd0, irq_a_n}, 8'h00);
      wr(4'h4, 8'h01);
      repeat (2) @(negedge clk);
      chk("R7 second clear sticks", {7'd0, irq_a_n}, 8'h01);
      wr(4'h0, 8'h00);
      src_in[0] = 1'b1; wait3();
      src_in[0] = 1'b0; wait3();
      wr(4'h4, 8'h01);
      @(negedge clk);
      chk("R7 no pending mode loses event", {7'd0, irq_a_n}, 8'h01);
   endtask

   task automatic t_same();
      logic [7:0] v;
      src_in[0] = 1'b1; wait3();
      src_in[0] = 1'b0;
      repeat (2) @(negedge clk);
      wr(4'h4, 8'h01);
      chk("R8 edge wins over clear", {7'd0, irq_a_n}, 8'h00);
      rd(4'h4, v); chk("R8 status still set", v, 8'h01);
      wr(4'h4, 8'h01);
   endtask

   task automatic t_prim();
      logic [7:0] v;
      other_req_a = 8'h81;
      rd(4'h1, v); chk("R9 own slot input ignored", v, 8'h80);
      chk("R10 sibling request drives irq", {7'd0, irq_a_n}, 8'h00);
      other_req_a = 8'h00;
      @(negedge clk);
      chk("R10 irq released", {7'd0, irq_a_n}, 8'h01);
      src_in[0] = 1'b1; wait3();
      rd(4'h1, v); chk("R9 own slot request", v, 8'h01);
      other_req_b = 8'h40;
      rd(4'h2, v); chk("R9 line B summary", v, 8'h40);
      chk("R10 irq_b from sibling", {7'd0, irq_b_n}, 8'h00);
      other_req_b = 8'h00;
      wr(4'h4, 8'h01);
      src_in[0] = 1'b0; wait3();
      wr(4'h4, 8'h01);
   endtask

   task automatic t_snap();
      logic [7:0] v;
      wr(4'h0, 8'h01);
      wr(4'hE, 8'h28);
      src_in[9] = 1'b1; wait3();
      rd(4'h4, v); chk("R12 low byte empty", v, 8'h00);
      src_in[10] = 1'b1; wait3();
      rd(4'h5, v); chk("R12 high byte from snapshot", v, 8'h02);
      rd(4'h4, v);
      rd(4'h5, v); chk("R12 unreturned bit survived", v, 8'h04);
      rd(4'h4, v);
      rd(4'h5, v); chk("R12 all cleared", v, 8'h00);
      chk("R12 irq released", {7'd0, irq_a_n}, 8'h01);
      wr(4'h0, 8'h00);
   endtask

   task automatic t_hi();
      logic [7:0] v;
      wr(4'h7, 8'hFF);
      rd(4'h7, v); chk("R13 upper mask bits zero", v, 8'h0F);
      rd(4'hF, v); chk("R13 unused edge byte zero", v, 8'h00);
      wr(4'h7, 8'h00);
   endtask

   initial begin
      rst_n = 1'b0; src_in = '0; other_req_a = '0; other_req_b = '0;
      addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unselected();
      t_rise();
      t_fall();
      t_both();
      t_mask();
      t_w1c_keeps();
      t_lines();
      t_cor();
      t_pend();
      t_same();
      t_prim();
      t_snap();
      t_hi();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule